// File: doc/BRIEF.md
# Packed Quadword Logical Left Shifter

This unit is one SIMD execution slice. It takes a 128-bit data operand, splits it into two independent 64-bit lanes, and shifts both lanes left logically by one shared count. Bits are never passed from one lane to the next, and the positions emptied at the low end of a lane are filled with zeros.

The count has two possible sources, picked by a decoded form select. In the register form it is the whole low 64-bit half of a second 128-bit operand. In the immediate form it is an unsigned 8-bit value. The unit checks the full count and never wraps it to six bits. So a count of 64 or more, in either form, empties both lanes. The result and a valid flag come out of a register one clock after the input strobe. Lane width, operand width, immediate width and the shifter structure are all parameters.

Top module: `qshl_top`

## Requirements
- R1: Lane 0 is bits 63:0 and lane 1 is bits 127:64 of the data operand. Each lane is shifted on its own, and no bit moves from lane 0 into lane 1.
- R2: Bit positions emptied at the low end of each lane by a non-zero, in-range shift become 0.
- R3: When `use_imm` is 0 (register form), the count is the unsigned value of `src_count[63:0]`, and `src_count[127:64]` and `imm_count` have no effect on the result.
- R4: When `use_imm` is 1 (immediate form), the count is the unsigned 8-bit value of `imm_count`, and `src_count` has no effect on the result.
- R5: A count greater than 63 makes the whole 128-bit result zero. This includes 64, 255 and register-form counts whose only set bits lie above bit 5 (for example 2^40). The count is never taken modulo 64.
- R6: A count of 0 returns both lanes unchanged.
- R7: A count of 63 leaves each lane holding only its original bit 0, moved to the lane's bit 63, with every other bit zero.
- R8: `out_valid` is high in exactly the cycle after an edge at which `in_valid` was high, and `result` then holds the shifted value. When `in_valid` is low at an edge, `result` keeps its value.
- R9: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| use_imm | input | 1 | Form select: 0 register count, 1 immediate count |
| src_data | input | 128 | Packed data operand, two 64-bit lanes |
| src_count | input | 128 | Count operand; only bits 63:0 are used |
| imm_count | input | 8 | Immediate count, unsigned |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 128 | Registered shifted lanes |

## Verification
The hardest case to reach from the ports is a register-form count whose six low bits are small or zero while some upper bit is set. A design that wraps the count would shift by a legal amount there, when it must return zero. The stimulus reaches this case on purpose: it places single high bits such as 2^40 and 2^63, and counts like 64 plus a small offset, into `src_count[63:0]`, while random values fill the ignored upper half and the immediate. A full sweep of all 256 immediate values, and of register counts 0 through 72, covers both sides of the 63/64 boundary in both forms.

// File: rtl/qshl_pkg.sv
package qshl_pkg;

   // Form select encoding seen on the use_imm port
   typedef enum logic {
      FORM_REG = 1'b0,
      FORM_IMM = 1'b1
   } qshl_form_e;

   // Shifter structure variants
   localparam int unsigned SHIFT_LOG    = 0;
   localparam int unsigned SHIFT_DIRECT = 1;

   function automatic int unsigned amt_bits(input int unsigned lane_w);
      return (lane_w <= 1) ? 1 : $clog2(lane_w);
   endfunction

endpackage

// File: rtl/qshl_count_sel.sv
module qshl_count_sel #(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned IMM_W  = 8,
   localparam int unsigned SH_W  = qshl_pkg::amt_bits(LANE_W)
) (
   input  logic              use_imm,
   input  logic [LANE_W-1:0] reg_count,
   input  logic [IMM_W-1:0]  imm_count,
   output logic [SH_W-1:0]   amt,
   output logic              zero_all
);
   import qshl_pkg::*;

   logic reg_over;
   logic imm_over;
   logic [SH_W-1:0] reg_amt;
   logic [SH_W-1:0] imm_amt;

   // The register count is always wider than the shift amount field
   assign reg_over = |reg_count[LANE_W-1:SH_W];
   assign reg_amt  = reg_count[SH_W-1:0];

   generate
      if (IMM_W > SH_W) begin : g_imm_wide
         assign imm_over = |imm_count[IMM_W-1:SH_W];
         assign imm_amt  = imm_count[SH_W-1:0];
      end else begin : g_imm_narrow
         assign imm_over = 1'b0;
         assign imm_amt  = SH_W'(imm_count);
      end
   endgenerate

   always_comb begin
      if (qshl_form_e'(use_imm) == FORM_IMM) begin
         amt      = imm_amt;
         zero_all = imm_over;
      end else begin
         amt      = reg_amt;
         zero_all = reg_over;
      end
   end

endmodule

// File: rtl/qshl_lane.sv
module qshl_lane #(
   parameter int unsigned LANE_W     = 64,
   parameter int unsigned SHIFT_IMPL = 0,
   localparam int unsigned SH_W      = qshl_pkg::amt_bits(LANE_W)
) (
   input  logic [LANE_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   input  logic              zero_all,
   output logic [LANE_W-1:0] dout
);
   import qshl_pkg::*;

   logic [LANE_W-1:0] shifted;

   generate
      if (SHIFT_IMPL == SHIFT_LOG) begin : g_log
         logic [LANE_W-1:0] stage [SH_W+1];
         assign stage[0] = din;
         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            localparam int unsigned STEP = 1 << s;
            if (STEP < LANE_W) begin : g_mv
               assign stage[s+1] = amt[s]
                  ? {stage[s][LANE_W-1-STEP:0], {STEP{1'b0}}}
                  : stage[s];
            end else begin : g_clr
               assign stage[s+1] = amt[s] ? '0 : stage[s];
            end
         end
         assign shifted = stage[SH_W];
      end else begin : g_direct
         assign shifted = din << amt;
      end
   endgenerate

   assign dout = zero_all ? '0 : shifted;

endmodule

// File: rtl/qshl_top.sv
module qshl_top #(
   parameter int unsigned DATA_W     = 128,
   parameter int unsigned LANE_W     = 64,
   parameter int unsigned IMM_W      = 8,
   parameter int unsigned SHIFT_IMPL = qshl_pkg::SHIFT_LOG
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] src_data,
   input  logic [DATA_W-1:0] src_count,
   input  logic [IMM_W-1:0]  imm_count,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   import qshl_pkg::*;

   localparam int unsigned NUM_LANES = DATA_W / LANE_W;
   localparam int unsigned SH_W      = amt_bits(LANE_W);

   generate
      if (LANE_W < 2) begin : g_bad_lane
         $error("qshl_top: LANE_W must be at least 2");
      end
      if (DATA_W % LANE_W != 0) begin : g_bad_split
         $error("qshl_top: DATA_W must be a multiple of LANE_W");
      end
      if (IMM_W < 1) begin : g_bad_imm
         $error("qshl_top: IMM_W must be at least 1");
      end
      if (SHIFT_IMPL > SHIFT_DIRECT) begin : g_bad_impl
         $error("qshl_top: unknown SHIFT_IMPL");
      end
   endgenerate

   logic [SH_W-1:0]   amt;
   logic              zero_all;
   logic [DATA_W-1:0] next_res;

   // Upper count bits are architecturally ignored
   generate
      if (DATA_W > LANE_W) begin : g_hi_cnt
         logic unused_cnt_hi;
         assign unused_cnt_hi = ^src_count[DATA_W-1:LANE_W];
      end
   endgenerate

   qshl_count_sel #(
      .LANE_W (LANE_W),
      .IMM_W  (IMM_W)
   ) u_cnt (
      .use_imm   (use_imm),
      .reg_count (src_count[LANE_W-1:0]),
      .imm_count (imm_count),
      .amt       (amt),
      .zero_all  (zero_all)
   );

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         qshl_lane #(
            .LANE_W     (LANE_W),
            .SHIFT_IMPL (SHIFT_IMPL)
         ) u_lane (
            .din      (src_data[l*LANE_W +: LANE_W]),
            .amt      (amt),
            .zero_all (zero_all),
            .dout     (next_res[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= next_res;
         end
      end
   end

endmodule

// File: rtl/qshl_chk.sv
module qshl_chk #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned IMM_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              use_imm,
   input logic [DATA_W-1:0] src_data,
   input logic [DATA_W-1:0] src_count,
   input logic [IMM_W-1:0]  imm_count,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   localparam int unsigned NUM_LANES = DATA_W / LANE_W;

   logic [LANE_W-1:0] cnt_eff;
   logic              cnt_over;

   assign cnt_eff  = use_imm ? LANE_W'(imm_count) : src_count[LANE_W-1:0];
   assign cnt_over = cnt_eff > LANE_W'(LANE_W - 1);

   // R9: reset leaves cleared outputs
   a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && result == '0));

   // R8: valid follows the strobe by one cycle
   a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R8: result holds when no strobe
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   // R5: out-of-range count empties both lanes
   a_r5_over_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cnt_over) |=> (result == '0));

   // R6: zero count passes data through
   a_r6_pass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cnt_eff == '0) |=> (result == $past(src_data)));

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
         // R7: maximal in-range count keeps only bit 0 at the top
         a_r7_top_bit: assert property (@(posedge clk) disable iff (rst)
            (in_valid && cnt_eff == LANE_W'(LANE_W - 1)) |=>
            (result[l*LANE_W +: LANE_W] ==
             {$past(src_data[l*LANE_W]), {(LANE_W-1){1'b0}}}));
         // R2: low end is zero-filled on any real shift
         a_r2_zero_fill: assert property (@(posedge clk) disable iff (rst)
            (in_valid && cnt_eff != '0 && !cnt_over) |=>
            (result[l*LANE_W] == 1'b0));
      end
   endgenerate

endmodule

bind qshl_top qshl_chk #(
   .DATA_W (DATA_W),
   .LANE_W (LANE_W),
   .IMM_W  (IMM_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .use_imm   (use_imm),
   .src_data  (src_data),
   .src_count (src_count),
   .imm_count (imm_count),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/qshl_top_test.sv
module qshl_top_test;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         use_imm;
   logic [127:0] src_data;
   logic [127:0] src_count;
   logic [7:0]   imm_count;
   logic         out_valid;
   logic [127:0] result;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qshl_top uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .use_imm   (use_imm),
      .src_data  (src_data),
      .src_count (src_count),
      .imm_count (imm_count),
      .out_valid (out_valid),
      .result    (result)
   );

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [127:0] expect_res(input logic [127:0] d,
                                                input logic [127:0] c,
                                                input logic [7:0] i,
                                                input logic u);
      logic [63:0] n;
      logic [63:0] lo;
      logic [63:0] hi;
      n = u ? {56'd0, i} : c[63:0];
      if (n >= 64) return '0;
      lo = d[63:0];
      hi = d[127:64];
      for (int k = 0; k < n; k++) begin
         lo = {lo[62:0], 1'b0};
         hi = {hi[62:0], 1'b0};
      end
      return {hi, lo};
   endfunction

   task automatic check(input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic run_op(input string req, input logic [127:0] d,
                         input logic [127:0] c, input logic [7:0] i,
                         input logic u);
      in_valid  = 1'b1;
      use_imm   = u;
      src_data  = d;
      src_count = c;
      imm_count = i;
      @(negedge clk);
      in_valid  = 1'b0;
      src_data  = rnd128();
      src_count = rnd128();
      imm_count = 8'($urandom);
      check({req, " valid"}, {127'd0, out_valid}, 128'd1);
      check(req, result, expect_res(d, c, i, u));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [127:0] d;
      logic [127:0] held;
      rst       = 1'b1;
      in_valid  = 1'b0;
      use_imm   = 1'b0;
      src_data  = '0;
      src_count = '0;
      imm_count = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 reset result", result, '0);
      check("R9 reset valid", {127'd0, out_valid}, '0);
      rst = 1'b0;
      @(negedge clk);

      // R6: zero count, both forms
      run_op("R6 reg zero", rnd128(), {rnd128() & {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}}, 8'($urandom), 1'b0);
      run_op("R6 imm zero", rnd128(), rnd128(), 8'd0, 1'b1);
      // R7: count 63
      run_op("R7 reg 63", '1, {64'($urandom), 64'd63}, 8'd0, 1'b0);
      run_op("R7 imm 63", 128'h1_0000_0000_0000_0001, rnd128(), 8'd63, 1'b1);
      // R1: low lane top bits must not appear in high lane
      run_op("R1 no carry", {64'd0, 64'hFFFF_0000_0000_0000}, {64'd0, 64'd8}, 8'd0, 1'b0);
      run_op("R1 no carry imm", {64'h1, 64'h8000_0000_0000_0000}, '0, 8'd1, 1'b1);
      // R2: zero fill with all-ones data
      run_op("R2 fill 1", '1, {64'd0, 64'd1}, 8'd0, 1'b0);
      run_op("R2 fill 37", '1, '0, 8'd37, 1'b1);

      // R3 and R5: register-form sweep across the boundary, random upper half
      for (int c = 0; c <= 72; c++) begin
         run_op("R3 reg sweep", rnd128(), {64'($urandom), 64'(c)}, 8'($urandom), 1'b0);
      end
      // R4 and R5: full immediate sweep, random count operand
      for (int c = 0; c < 256; c++) begin
         run_op("R4 imm sweep", rnd128(), rnd128(), 8'(c), 1'b1);
      end
      // R5: high-only counts in register form
      run_op("R5 2^40", '1, {64'd0, 64'h0000_0100_0000_0000}, 8'd0, 1'b0);
      run_op("R5 2^63", '1, {64'd0, 64'h8000_0000_0000_0000}, 8'd0, 1'b0);
      run_op("R5 64+3", '1, {64'd0, 64'd67}, 8'd3, 1'b0);
      run_op("R5 255 reg", '1, {64'd0, 64'd255}, 8'd0, 1'b0);
      for (int b = 6; b < 64; b++) begin
         run_op("R5 single high bit", rnd128(), {rnd128() & {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}} | (128'd1 << b), 8'd2, 1'b0);
      end
      // R3: imm ignored in register form; R4: count ignored in imm form
      run_op("R3 imm ignored", '1, {64'hFFFF_FFFF_FFFF_FFFF, 64'd4}, 8'd200, 1'b0);
      run_op("R4 count ignored", '1, {64'd0, 64'd200}, 8'd4, 1'b1);

      // R8: hold with no strobe while inputs wander
      d = rnd128();
      run_op("R8 load", d, {64'd0, 64'd5}, 8'd0, 1'b0);
      held = result;
      for (int k = 0; k < 4; k++) begin
         src_data  = rnd128();
         src_count = '0;
         imm_count = 8'd1;
         use_imm   = k[0];
         @(negedge clk);
         check("R8 hold result", result, held);
         check("R8 hold valid", {127'd0, out_valid}, '0);
      end

      // R9: reset mid-run
      run_op("R9 pre", '1, '0, 8'd0, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R9 mid result", result, '0);
      check("R9 mid valid", {127'd0, out_valid}, '0);
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule